// File: doc/BRIEF.md
# Transmit Sample Nibble Deserializer

This block sits between the modem processor's nibble-wide transmit bus and the transmit DAC. Each transmit sample arrives as four 4-bit nibbles on consecutive nibble-enable cycles, least significant nibble first. The block puts the 16-bit signed word back together and drops its three padding bits at the bottom. It then produces a 12-bit two's complement DAC code made of one sign bit and eleven data bits.

The word carries its sign twice, in the two top bits. When the two copies disagree, the word lies outside the range the DAC can represent. In that case the block saturates the code to the full-scale limit on the side given by the top bit, instead of truncating the word, and raises an overflow flag. A word strobe that arrives with a nibble marks the first nibble of a word and restarts the nibble count. Any partial or unframed nibbles are therefore thrown away.

Both sample-rate modes use the same logic. Only the spacing of the nibble enables changes between them. While power-down is held, the block ignores the transmit bus and keeps the last DAC code.

Top module: `tx_nibble_deser`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `dac_code` is 0, `dac_ovf` is 0 and `dac_upd` is 0.
- R2: Nibble k of a word (k = 0 first) fills word bits 4k+3..4k, with lane i going to bit 4k+i. When bits 15 and 14 agree, `dac_code` equals word bits 14..3, so bit 14 is the sign and bits 13..3 are the data. Bits 2..0 have no effect.
- R3: If word bit 15 is 0 and bit 14 is 1, `dac_code` is 12'h7FF and `dac_ovf` is 1.
- R4: If word bit 15 is 1 and bit 14 is 0, `dac_code` is 12'h800 and `dac_ovf` is 1.
- R5: `dac_code`, `dac_ovf` and a one-cycle `dac_upd` pulse all change on the clock edge after the edge that captures the fourth nibble. Between updates `dac_code` holds its value.
- R6: A nibble captured with `word_sync` high is nibble 0. Any partly received word before it is discarded and produces no update.
- R7: After reset, nibbles are ignored until the first nibble that comes with `word_sync`.
- R8: While `pdown` is high, `nib_en` and `word_sync` are ignored, no update happens and `dac_code` is held. Framing is lost, so after `pdown` falls a new `word_sync` is needed.
- R9: Any number of idle cycles between nibble enables, including none, gives the same result.
- R10: `dac_ovf` describes only the most recent word. An in-range word that follows an overflowed one clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pdown | input | 1 | Power-down, freezes the block |
| nib_en | input | 1 | Nibble valid on `tx_nib` this cycle |
| word_sync | input | 1 | Marks the current nibble as nibble 0 |
| tx_nib | input | 4 | Transmit nibble bus |
| dac_code | output | 12 | Two's complement DAC code |
| dac_upd | output | 1 | One-cycle pulse when a new code is presented |
| dac_ovf | output | 1 | Most recent word was saturated |

## Verification
A wrong nibble index or a lane mix-up shows up as a wrong `dac_code` in the very next update pulse, so each table vector uses a distinct bit pattern. A stale alignment flag or a counter that failed to restart shows up as an extra or missing `dac_upd` pulse, or as a code built from a mixture of two words, within one word time. For that reason the bench counts pulses around every orphan nibble, partial word and power-down sequence. A wrong clamp polarity or a sticky overflow bit shows up in the update that directly follows the offending word.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [1:0] {
    SGN_AGREE   = 2'd0,
    SGN_POS_OVF = 2'd1,
    SGN_NEG_OVF = 2'd2
  } sign_stat_t;

  // Classify the duplicated sign pair of a rebuilt word.
  function automatic sign_stat_t sign_classify(input logic top_b, input logic next_b);
    if (top_b == next_b) return SGN_AGREE;
    else if (!top_b)     return SGN_POS_OVF;
    else                 return SGN_NEG_OVF;
  endfunction

endpackage

// File: rtl/nib_frame_ctr.sv
module nib_frame_ctr #(
  parameter int NIBS = 4,
  localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pdown,
  input  logic             nib_en,
  input  logic             word_sync,
  output logic             cap_en,
  output logic [IDX_W-1:0] cap_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

  logic             aligned_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || pdown) begin
      aligned_q <= 1'b0;
      idx_q     <= '0;
    end else if (nib_en) begin
      if (word_sync) begin
        aligned_q <= 1'b1;
        idx_q     <= IDX_W'(1);
      end else if (aligned_q) begin
        idx_q <= (idx_q == LAST_IDX) ? '0 : IDX_W'(idx_q + 1'b1);
      end
    end
  end

  assign cap_en  = nib_en && !pdown && (word_sync || aligned_q);
  assign cap_idx = word_sync ? '0 : idx_q;

  // R7
  ctr_align_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned_q) |-> $past(nib_en && word_sync && !pdown));

  // R8
  ctr_pdown_drop_chk: assert property (@(posedge clk) disable iff (rst)
    pdown |=> !aligned_q);

endmodule

// File: rtl/nib_word_asm.sv
module nib_word_asm #(
  parameter int NIB_W   = 4,
  parameter int NIBS    = 4,
  parameter int PAD_LSB = 3,
  localparam int WORD_W = NIB_W * NIBS,
  localparam int IDX_W  = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cap_en,
  input  logic [IDX_W-1:0]          cap_idx,
  input  logic [NIB_W-1:0]          nib,
  output logic [WORD_W-1:PAD_LSB]   word,
  output logic                      word_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

  logic [NIBS-1:0]            slot_we;
  logic [WORD_W-1:PAD_LSB]    word_q;
  logic                       done_q;

  for (genvar k = 0; k < NIBS; k++) begin : g_we
    assign slot_we[k] = cap_en && (cap_idx == IDX_W'(k));
  end

  // One flop per kept word bit; padding bits are never stored.
  for (genvar b = PAD_LSB; b < WORD_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                     word_q[b] <= 1'b0;
      else if (slot_we[b / NIB_W]) word_q[b] <= nib[b % NIB_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= cap_en && (cap_idx == LAST_IDX);
  end

  assign word      = word_q;
  assign word_done = done_q;

  // R6
  asm_one_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_we));

  // R5
  asm_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);

endmodule

// File: rtl/tx_code_sat.sv
module tx_code_sat #(
  parameter int WORD_W  = 16,
  parameter int PAD_LSB = 3,
  localparam int CODE_W = WORD_W - 1 - PAD_LSB
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pdown,
  input  logic                    word_done,
  input  logic [WORD_W-1:PAD_LSB] word,
  output logic [CODE_W-1:0]       code,
  output logic                    ovf,
  output logic                    upd
);
  import txd_pkg::*;

  localparam logic [CODE_W-1:0] CODE_MAX = {1'b0, {(CODE_W-1){1'b1}}};
  localparam logic [CODE_W-1:0] CODE_MIN = {1'b1, {(CODE_W-1){1'b0}}};

  sign_stat_t          stat;
  logic [CODE_W-1:0]   code_d;
  logic [CODE_W-1:0]   code_q;
  logic                ovf_q;
  logic                upd_q;

  assign stat = sign_classify(word[WORD_W-1], word[WORD_W-2]);

  always_comb begin
    unique case (stat)
      SGN_POS_OVF: code_d = CODE_MAX;
      SGN_NEG_OVF: code_d = CODE_MIN;
      default:     code_d = word[WORD_W-2:PAD_LSB];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      ovf_q  <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= word_done && !pdown;
      if (word_done && !pdown) begin
        code_q <= code_d;
        ovf_q  <= (stat != SGN_AGREE);
      end
    end
  end

  assign code = code_q;
  assign ovf  = ovf_q;
  assign upd  = upd_q;

  // R8
  sat_pdown_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pdown |=> ($stable(code_q) && !upd_q));

  // R3
  sat_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_q && ovf_q) |-> (code_q == CODE_MAX || code_q == CODE_MIN));

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_q |-> $stable(code_q));

endmodule

// File: rtl/tx_nibble_deser.sv
module tx_nibble_deser #(
  parameter int NIB_W   = 4,
  parameter int NIBS    = 4,
  parameter int PAD_LSB = 3,
  localparam int WORD_W = NIB_W * NIBS,
  localparam int CODE_W = WORD_W - 1 - PAD_LSB,
  localparam int IDX_W  = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdown,
  input  logic              nib_en,
  input  logic              word_sync,
  input  logic [NIB_W-1:0]  tx_nib,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_upd,
  output logic              dac_ovf
);
  logic                    cap_en;
  logic [IDX_W-1:0]        cap_idx;
  logic [WORD_W-1:PAD_LSB] word;
  logic                    word_done;

  nib_frame_ctr #(.NIBS(NIBS)) frame_i (
    .clk(clk), .rst(rst), .pdown(pdown), .nib_en(nib_en),
    .word_sync(word_sync), .cap_en(cap_en), .cap_idx(cap_idx)
  );

  nib_word_asm #(.NIB_W(NIB_W), .NIBS(NIBS), .PAD_LSB(PAD_LSB)) asm_i (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_idx(cap_idx),
    .nib(tx_nib), .word(word), .word_done(word_done)
  );

  tx_code_sat #(.WORD_W(WORD_W), .PAD_LSB(PAD_LSB)) sat_i (
    .clk(clk), .rst(rst), .pdown(pdown), .word_done(word_done),
    .word(word), .code(dac_code), .ovf(dac_ovf), .upd(dac_upd)
  );

  // R5
  top_upd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (word_done && !pdown) |=> dac_upd);

  // R10
  top_ovf_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_upd && (dac_code != {1'b0, {(CODE_W-1){1'b1}}})
             && (dac_code != {1'b1, {(CODE_W-1){1'b0}}})) |-> !dac_ovf);

endmodule

// File: tb/tx_nibble_deser_tb_top.sv
module tx_nibble_deser_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdown = 1'b0;
  logic nib_en = 1'b0;
  logic word_sync = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic [11:0] dac_code;
  logic dac_upd;
  logic dac_ovf;

  int checks = 0;
  int errors = 0;
  int upd_count = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tx_nibble_deser dut_i (
    .clk(clk), .rst(rst), .pdown(pdown), .nib_en(nib_en),
    .word_sync(word_sync), .tx_nib(tx_nib),
    .dac_code(dac_code), .dac_upd(dac_upd), .dac_ovf(dac_ovf)
  );

  always @(posedge clk) if (!rst && dac_upd) upd_count <= upd_count + 1;

  // {word[15:0], expected code[11:0], expected ovf}
  localparam logic [28:0] VEC [10] = '{
    {16'h0008, 12'h001, 1'b0},
    {16'h3FF8, 12'h7FF, 1'b0},
    {16'hC000, 12'h800, 1'b0},
    {16'hFFF8, 12'hFFF, 1'b0},
    {16'h4000, 12'h7FF, 1'b1},
    {16'h8000, 12'h800, 1'b1},
    {16'h7FFF, 12'h7FF, 1'b1},
    {16'h1237, 12'h246, 1'b0},
    {16'hBFF8, 12'h800, 1'b1},
    {16'h0007, 12'h000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives nn nibbles, returns at the negedge after the last capture.
  task automatic send(input logic [15:0] w, input logic sync_first, input int gap, input int nn);
    for (int k = 0; k < nn; k++) begin
      nib_en    = 1'b1;
      word_sync = sync_first && (k == 0);
      tx_nib    = w[4*k +: 4];
      @(negedge clk);
      nib_en    = 1'b0;
      word_sync = 1'b0;
      if (k < nn - 1) repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 code", dac_code, 0);
    chk("R1 ovf", dac_ovf, 0);
    chk("R1 upd", dac_upd, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 upd after release", dac_upd, 0);

    // R7: unframed nibbles after reset
    send(16'h4444, 1'b0, 0, 4);
    send(16'h5555, 1'b0, 0, 4);
    repeat (3) @(negedge clk);
    chk("R7 no update", upd_count, 0);
    chk("R7 code", dac_code, 0);

    // Table walk: R2 R3 R4 R5 R9 R10
    for (int i = 0; i < 10; i++) begin
      logic [15:0] w;
      logic [11:0] ec;
      logic eo;
      string tag;
      w  = VEC[i][28:13];
      ec = VEC[i][12:1];
      eo = VEC[i][0];
      tag = eo ? ((ec == 12'h7FF) ? "R3" : "R4") : ((i > 0 && VEC[i-1][0]) ? "R10" : "R2");
      base = upd_count;
      send(w, 1'b1, i % 3, 4);
      chk("R5 no early upd", dac_upd, 0);
      @(negedge clk);
      chk("R5 upd pulse", dac_upd, 1);
      chk((i % 3 != 0) ? "R9 code" : {tag, " code"}, dac_code, ec);
      chk({tag, " ovf"}, dac_ovf, eo);
      @(negedge clk);
      chk("R5 single pulse", dac_upd, 0);
      chk("R5 code held", dac_code, ec);
      chk("R5 one update", upd_count, base + 1);
    end

    // R6: partial word then a fresh framed word
    base = upd_count;
    send(16'hFFFF, 1'b1, 0, 2);
    send(16'h0010, 1'b1, 0, 4);
    repeat (2) @(negedge clk);
    chk("R6 one update", upd_count, base + 1);
    chk("R6 code", dac_code, 12'h002);
    chk("R6 ovf", dac_ovf, 0);

    // R8: power-down ignores the bus and drops framing
    base = upd_count;
    pdown = 1'b1;
    send(16'h4000, 1'b1, 0, 4);
    repeat (2) @(negedge clk);
    chk("R8 no update in pdown", upd_count, base);
    chk("R8 code held", dac_code, 12'h002);
    pdown = 1'b0;
    @(negedge clk);
    send(16'h4000, 1'b0, 0, 4);
    repeat (2) @(negedge clk);
    chk("R8 needs resync", upd_count, base);
    chk("R8 ovf held", dac_ovf, 0);
    send(16'h4000, 1'b1, 1, 4);
    repeat (2) @(negedge clk);
    chk("R8 resync update", upd_count, base + 1);
    chk("R8 resync code", dac_code, 12'h7FF);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R1 code after rerst", dac_code, 0);
    chk("R1 ovf after rerst", dac_ovf, 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule